// File: doc/BRIEF.md
# Packed Floating-Point Minimum Unit

This block is a purely combinational SIMD datapath. It takes two packed vectors of IEEE binary floating-point elements and returns their element-wise minimum. A 2-bit width selector splits the vector into 16-, 32- or 64-bit lanes. Every lane is computed; there is no predicate mask. The result is a vector of the same width, placed lane for lane.

Two mode inputs decide how signed zeros and NaNs are resolved. With the alternate flag clear, the block follows IEEE-style ordering, in which negative zero sorts below positive zero. In that mode a NaN input either propagates as a quieted NaN or is replaced by the canonical default NaN, depending on the default-NaN flag. With the alternate flag set, the block hands back the second operand untouched whenever both inputs are zeros or either input is a NaN.

A flag reports any signaling NaN seen in any lane. The reserved width code is reported on its own output, and in that case operand one passes straight through.

Top module: `fpmin_vec`

## Requirements
- R1: The width selector `size_i` chooses the lane width as 8 shifted left by its value: 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits. The vector holds VEC_W divided by that width lanes, with lane k at bits [k*EW +: EW], and each lane is computed independently of the others.
- R2: For operands that are neither NaNs nor a pair of zeros, the lane result is the smaller value. When the signs differ, the negative operand is returned. When both are positive, the one with the smaller magnitude is returned. When both are negative, the one with the larger magnitude is returned. Infinities follow the same rule.
- R3: With `alt_mode_i`=0, negative zero is treated as less than positive zero. min(+0,-0) and min(-0,+0) both return -0 (sign bit set, all other bits clear).
- R4: With `alt_mode_i`=0 and `dflt_nan_i`=0, a NaN in either operand yields a quiet NaN. A signaling NaN is chosen over a quiet one, and operand one is chosen over operand two. The chosen NaN is quieted by setting the top fraction bit. A NaN has an all-ones exponent and a nonzero fraction; it is signaling when the top fraction bit is 0.
- R5: With `alt_mode_i`=0 and `dflt_nan_i`=1, a NaN in either operand yields the default NaN. That value has sign 0, an all-ones exponent, the top fraction bit set and the other fraction bits clear: 0x7E00, 0x7FC00000 and 0x7FF8000000000000 for the three widths.
- R6: With `alt_mode_i`=1, when both operands are zeros of any signs, the result is operand two bit for bit.
- R7: With `alt_mode_i`=1, when either operand is a NaN, the result is operand two bit for bit, whatever the value of `dflt_nan_i`.
- R8: For a valid width code, `inv_op_o` is 1 exactly when some lane of either operand holds a signaling NaN. This holds in both modes.
- R9: Width code 00 is reserved. It sets `bad_size_o` to 1, drives `res_o` equal to `opa_i`, and holds `inv_op_o` at 0. For valid codes `bad_size_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | VEC_W | First operand vector, packed lanes |
| opb_i | input | VEC_W | Second operand vector, packed lanes |
| size_i | input | 2 | Lane width code (00 reserved, 01/10/11 = 16/32/64) |
| alt_mode_i | input | 1 | Alternate zero/NaN handling select |
| dflt_nan_i | input | 1 | Replace NaN results with the default NaN (alternate mode off only) |
| res_o | output | VEC_W | Element-wise minimum |
| bad_size_o | output | 1 | Reserved width code seen |
| inv_op_o | output | 1 | A signaling NaN is present in some lane |

## Verification
The embedded checks are immediate assertions evaluated whenever the combinational inputs settle. They take for granted that every input bit is a defined 0 or 1, and that the width code does not change between the point where the inputs are applied and the point where the result is sampled. The stimulus respects both conditions: it drives all inputs together on the falling clock edge, from fully specified constants, and reads the outputs a nanosecond later, before anything else moves. No timing relation between operands is assumed, because the block holds no state.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_H16  = 2'b01,
    SZ_S32  = 2'b10,
    SZ_D64  = 2'b11
  } lane_size_e;

  // Number of supported lane formats (16, 32, 64)
  localparam int unsigned NUM_FMT = 3;

  // Exponent width of the IEEE binary format for a given total width
  function automatic int unsigned exp_width(input int unsigned ew);
    if (ew == 16)      return 5;
    else if (ew == 32) return 8;
    else               return 11;
  endfunction

endpackage

// File: rtl/fpmin_lane.sv
module fpmin_lane
  import fpmin_pkg::*;
#(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          alt_i,
  input  logic          dn_i,
  output logic [EW-1:0] res_o,
  output logic          snan_o
);

  localparam int unsigned EXP_W  = exp_width(EW);
  localparam int unsigned FRAC_W = EW - 1 - EXP_W;
  localparam logic [EW-1:0] DFLT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [EW-1:0] QBIT = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              a_sgn, b_sgn;
  logic [EXP_W-1:0]  a_exp, b_exp;
  logic [FRAC_W-1:0] a_frc, b_frc;
  logic              a_nan, b_nan, a_snan, b_snan, a_zero, b_zero;
  logic              a_mag_lt, pick_a;
  logic [EW-1:0]     nan_sel, ord_sel;

  // field split
  always_comb begin
    a_sgn = a_i[EW-1];
    b_sgn = b_i[EW-1];
    a_exp = a_i[EW-2 -: EXP_W];
    b_exp = b_i[EW-2 -: EXP_W];
    a_frc = a_i[FRAC_W-1:0];
    b_frc = b_i[FRAC_W-1:0];
  end

  // classification
  always_comb begin
    a_nan  = (&a_exp) && (|a_frc);
    b_nan  = (&b_exp) && (|b_frc);
    a_snan = a_nan && !a_frc[FRAC_W-1];
    b_snan = b_nan && !b_frc[FRAC_W-1];
    a_zero = (a_exp == '0) && (a_frc == '0);
    b_zero = (b_exp == '0) && (b_frc == '0);
  end

  // ordered compare by sign and magnitude
  always_comb begin
    a_mag_lt = (a_i[EW-2:0] < b_i[EW-2:0]);
    if (a_sgn != b_sgn) pick_a = a_sgn;
    else if (!a_sgn)    pick_a = a_mag_lt;
    else                pick_a = !a_mag_lt;
    ord_sel = pick_a ? a_i : b_i;
  end

  // NaN propagation: signaling first, then operand one
  always_comb begin
    if (a_snan)      nan_sel = a_i | QBIT;
    else if (b_snan) nan_sel = b_i | QBIT;
    else if (a_nan)  nan_sel = a_i;
    else             nan_sel = b_i | QBIT;
  end

  // final selection
  always_comb begin
    if (alt_i && ((a_zero && b_zero) || a_nan || b_nan)) begin
      res_o = b_i;
    end else if (a_nan || b_nan) begin
      res_o = dn_i ? DFLT_NAN : nan_sel;
    end else begin
      res_o = ord_sel;
    end
    snan_o = a_snan || b_snan;
  end

  // embedded checks
  always_comb begin
    if (alt_i && (a_nan || b_nan))
      AST_ALT_NAN_TAKES_B: assert (res_o == b_i); // R7
    if (alt_i && a_zero && b_zero)
      AST_ALT_ZERO_TAKES_B: assert (res_o == b_i); // R6
    if (!alt_i && (a_nan || b_nan))
      AST_NAN_OUT_QUIET: assert ((&res_o[EW-2 -: EXP_W]) && res_o[FRAC_W-1]); // R4
    if (!alt_i && dn_i && (a_nan || b_nan))
      AST_DN_CANON: assert (res_o[EW-1] == 1'b0 && res_o[FRAC_W-2:0] == '0); // R5
    if (!a_nan && !b_nan && !(a_zero && b_zero))
      AST_ORD_IS_OPERAND: assert (res_o == a_i || res_o == b_i); // R2
    if (!alt_i && a_zero && b_zero)
      AST_ZERO_SIGN_OR: assert (res_o[EW-1] == (a_sgn || b_sgn)); // R3
  end

endmodule

// File: rtl/fpmin_slice.sv
module fpmin_slice
  import fpmin_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 32
) (
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic             alt_i,
  input  logic             dn_i,
  output logic [VEC_W-1:0] res_o,
  output logic             snan_o
);

  localparam int unsigned LANES = VEC_W / EW;

  logic [LANES-1:0] lane_snan;

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    fpmin_lane #(.EW(EW)) lane_i (
      .a_i    (opa_i[li*EW +: EW]),
      .b_i    (opb_i[li*EW +: EW]),
      .alt_i  (alt_i),
      .dn_i   (dn_i),
      .res_o  (res_o[li*EW +: EW]),
      .snan_o (lane_snan[li])
    );
  end

  assign snan_o = |lane_snan;

endmodule

// File: rtl/fpmin_vec.sv
module fpmin_vec
  import fpmin_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic [1:0]       size_i,
  input  logic             alt_mode_i,
  input  logic             dflt_nan_i,
  output logic [VEC_W-1:0] res_o,
  output logic             bad_size_o,
  output logic             inv_op_o
);

  logic [VEC_W-1:0] fmt_res  [NUM_FMT];
  logic [NUM_FMT-1:0] fmt_snan;

  for (genvar fi = 0; fi < NUM_FMT; fi++) begin : g_fmt
    localparam int unsigned FEW = 16 << fi;
    fpmin_slice #(.VEC_W(VEC_W), .EW(FEW)) slice_i (
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .alt_i  (alt_mode_i),
      .dn_i   (dflt_nan_i),
      .res_o  (fmt_res[fi]),
      .snan_o (fmt_snan[fi])
    );
  end

  always_comb begin
    bad_size_o = 1'b0;
    inv_op_o   = 1'b0;
    res_o      = opa_i;
    case (lane_size_e'(size_i))
      SZ_H16: begin res_o = fmt_res[0]; inv_op_o = fmt_snan[0]; end
      SZ_S32: begin res_o = fmt_res[1]; inv_op_o = fmt_snan[1]; end
      SZ_D64: begin res_o = fmt_res[2]; inv_op_o = fmt_snan[2]; end
      default: bad_size_o = 1'b1;
    endcase
  end

  always_comb begin
    if (size_i == 2'b00)
      AST_RSVD_PASSTHRU: assert (res_o == opa_i && !inv_op_o); // R9
    AST_BAD_SIZE_CODE: assert (bad_size_o == (size_i == 2'b00)); // R9
  end

endmodule

// File: tb/fpmin_vec_tb_top.sv
module fpmin_vec_tb_top;

  localparam int unsigned VW = 128;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  sz;
    logic        alt;
    logic        dn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] e;
    logic        inv;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{8'd2, 2'b01, 1'b0, 1'b0, 64'h3C00, 64'h4000, 64'h3C00, 1'b0},
    '{8'd2, 2'b01, 1'b0, 1'b0, 64'hBC00, 64'h3C00, 64'hBC00, 1'b0},
    '{8'd2, 2'b01, 1'b0, 1'b0, 64'hBC00, 64'hC000, 64'hC000, 1'b0},
    '{8'd2, 2'b01, 1'b0, 1'b0, 64'hFC00, 64'h3C00, 64'hFC00, 1'b0},
    '{8'd3, 2'b01, 1'b0, 1'b0, 64'h0000, 64'h8000, 64'h8000, 1'b0},
    '{8'd3, 2'b01, 1'b0, 1'b0, 64'h8000, 64'h0000, 64'h8000, 1'b0},
    '{8'd4, 2'b01, 1'b0, 1'b0, 64'h7E01, 64'h3C00, 64'h7E01, 1'b0},
    '{8'd4, 2'b01, 1'b0, 1'b0, 64'h3C00, 64'h7C01, 64'h7E01, 1'b1},
    '{8'd4, 2'b01, 1'b0, 1'b0, 64'h7E05, 64'h7C02, 64'h7E02, 1'b1},
    '{8'd4, 2'b01, 1'b0, 1'b0, 64'h7E05, 64'h7E07, 64'h7E05, 1'b0},
    '{8'd5, 2'b01, 1'b0, 1'b1, 64'h7E05, 64'h3C00, 64'h7E00, 1'b0},
    '{8'd6, 2'b01, 1'b1, 1'b0, 64'h0000, 64'h8000, 64'h8000, 1'b0},
    '{8'd6, 2'b01, 1'b1, 1'b0, 64'h8000, 64'h0000, 64'h0000, 1'b0},
    '{8'd7, 2'b01, 1'b1, 1'b0, 64'h7E05, 64'h3C00, 64'h3C00, 1'b0},
    '{8'd7, 2'b01, 1'b1, 1'b1, 64'h3C00, 64'h7C01, 64'h7C01, 1'b1},
    '{8'd2, 2'b01, 1'b1, 1'b0, 64'h4000, 64'h3C00, 64'h3C00, 1'b0},
    '{8'd1, 2'b10, 1'b0, 1'b0, 64'h3F800000, 64'hC0000000, 64'hC0000000, 1'b0},
    '{8'd5, 2'b10, 1'b0, 1'b1, 64'h7F800001, 64'h00000000, 64'h7FC00000, 1'b1},
    '{8'd1, 2'b11, 1'b0, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000,
      64'h3FF0000000000000, 1'b0},
    '{8'd4, 2'b11, 1'b0, 1'b0, 64'h7FF0000000000001, 64'h0000000000000000,
      64'h7FF8000000000001, 1'b1},
    '{8'd5, 2'b11, 1'b0, 1'b1, 64'h0000000000000000, 64'h7FF8000000000003,
      64'h7FF8000000000000, 1'b0},
    '{8'd9, 2'b00, 1'b0, 1'b0, 64'h7C01, 64'h3C00, 64'h7C01, 1'b0}
  };

  logic clk;
  logic rst_n;
  logic [VW-1:0] opa, opb, res;
  logic [1:0]    size;
  logic          alt, dn, bad_size, inv_op;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  fpmin_vec #(.VEC_W(VW)) dut_i (
    .opa_i      (opa),
    .opb_i      (opb),
    .size_i     (size),
    .alt_mode_i (alt),
    .dflt_nan_i (dn),
    .res_o      (res),
    .bad_size_o (bad_size),
    .inv_op_o   (inv_op)
  );

  function automatic logic [VW-1:0] fill(input logic [1:0] sz, input logic [63:0] v);
    logic [VW-1:0] r;
    int ew;
    ew = (sz == 2'b00) ? 16 : (8 << sz);
    r = '0;
    for (int k = 0; k < VW / ew; k++) begin
      for (int j = 0; j < ew; j++) r[k*ew + j] = v[j];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [1:0] s, input logic m, input logic d);
    @(negedge clk);
    opa = a; opb = b; size = s; alt = m; dn = d;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    opa = '0; opb = '0; size = 2'b01; alt = 1'b0; dn = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // initial state: zero inputs give positive zero, no flags (R3, R9)
    apply('0, '0, 2'b01, 1'b0, 1'b0);
    chk("R3 zero inputs", res, '0);
    chk("R9 bad_size low", {{(VW-1){1'b0}}, bad_size}, '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(fill(TBL[i].sz, TBL[i].a), fill(TBL[i].sz, TBL[i].b),
            TBL[i].sz, TBL[i].alt, TBL[i].dn);
      chk($sformatf("R%0d vec%0d res", TBL[i].req, i), res,
          (TBL[i].sz == 2'b00) ? fill(2'b00, TBL[i].a) : fill(TBL[i].sz, TBL[i].e));
      chk($sformatf("R8 vec%0d inv_op", i), {{(VW-1){1'b0}}, inv_op},
          {{(VW-1){1'b0}}, TBL[i].inv});
      chk($sformatf("R9 vec%0d bad_size", i), {{(VW-1){1'b0}}, bad_size},
          {{(VW-1){1'b0}}, (TBL[i].sz == 2'b00)});
    end

    // R1: distinct 32-bit lanes
    apply({32'h40400000, 32'h80000000, 32'h7FC00001, 32'h3F800000},
          {32'hC0000000, 32'h00000000, 32'h3F800000, 32'h40000000},
          2'b10, 1'b0, 1'b0);
    chk("R1 mixed 32-bit lanes", res,
        {32'hC0000000, 32'h80000000, 32'h7FC00001, 32'h3F800000});

    // R1: distinct 64-bit lanes
    apply({64'hBFF0000000000000, 64'h4008000000000000},
          {64'h3FF0000000000000, 64'h4000000000000000}, 2'b11, 1'b0, 1'b0);
    chk("R1 mixed 64-bit lanes", res,
        {64'hBFF0000000000000, 64'h4000000000000000});

    // R8: signaling NaN in a single 16-bit lane only
    apply({{7{16'h3C00}}, 16'h7C01}, {8{16'h4000}}, 2'b01, 1'b0, 1'b0);
    chk("R8 single lane snan", {{(VW-1){1'b0}}, inv_op}, {{(VW-1){1'b0}}, 1'b1});
    chk("R4 single lane quieted", res, {{7{16'h3C00}}, 16'h7E01});

    // R9: reserved size with alt and dn set still passes opa
    apply({4{32'h12345678}}, {4{32'h00000000}}, 2'b00, 1'b1, 1'b1);
    chk("R9 reserved passthru", res, {4{32'h12345678}});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule